// File: doc/BRIEF.md
# Mesh Egress Combiner and Router

This block sits at the exit side of a mesh node. It takes two message streams: pass-through traffic already travelling through the node toward some other node, and new messages produced by the node's own control logic. It merges them into a single stream under a strict priority, then sends each message to exactly one of the four neighbour links (north, east, south, west). The link is chosen only from the node's own grid coordinates and the target coordinates carried in the message header. Traffic for the host uses the same links: the host sits below the bottom row of the mesh.

Each message is `ROW_W + COL_W + PAYLOAD_W` bits wide. The target row is in the top `ROW_W` bits. The target column is in the next `COL_W` bits. The payload is in the low `PAYLOAD_W` bits. Row 0 is the top of the mesh, and rows increase toward the south. Column 0 is at the west edge, and columns increase toward the east. All interfaces follow the valid/ready rule: a transfer happens on a rising clock edge where valid and ready are both high. A source holds valid and data steady until that transfer. A ready value is only meaningful while the matching valid is high. Each egress link has a one-entry output register. That register can take a new message in the same cycle that it hands its current message downstream.

Top module: `egress_router`

## Requirements
- R1: When the pass-through and local inputs are both valid, the pass-through message is the one taken and `loc_ready` stays low. This holds even if the local message's link is free while the pass-through message is stalled.
- R2: A local message is taken when no pass-through message is valid and its chosen link register is empty, or is being emptied in the same cycle.
- R3: At most one message is taken per cycle, and each message taken appears on exactly one egress link.
- R4: If the target column is greater than the node's column, the message goes east (link index 1). If it is smaller, the message goes west (link index 3). The column is settled before the row.
- R5: If the target column equals the node's column, the message goes south (index 2) when the target row is greater than the node's row, and north (index 0) when it is smaller.
- R6: A target row of `NUM_ROWS` or more addresses the host. Such a message goes south whatever its target column.
- R7: A message whose target equals the node's own coordinates leaves on the south link.
- R8: While an egress link holds a message with its ready low, that link's valid and data stay unchanged. An input whose message is routed to that link sees ready low, and no message is lost.
- R9: A message taken at a clock edge appears on its link's valid and data right after that edge. The link's valid falls after a downstream transfer when nothing new is loaded.
- R10: An active-high synchronous reset clears every egress valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| my_col | input | COL_W | Column of this node |
| my_row | input | ROW_W | Row of this node |
| byp_valid | input | 1 | Pass-through message valid |
| byp_ready | output | 1 | Pass-through message accepted |
| byp_data | input | MSG_W | Pass-through message |
| loc_valid | input | 1 | Local message valid |
| loc_ready | output | 1 | Local message accepted |
| loc_data | input | MSG_W | Local message |
| out_valid | output | 4 | Egress valid per link (0 N, 1 E, 2 S, 3 W) |
| out_ready | input | 4 | Egress ready per link |
| out_data | output | 4 x MSG_W | Egress message per link |

## Verification
The hardest case to create from the ports is a pass-through message stuck behind a full link while a local message waits for a different link that is free. In that case the local message must still wait. The bench reaches it by holding one link's ready low. It loads that link with one pass-through message and then offers a second one for the same link, together with a local message bound east. It keeps this stall for several cycles before releasing it. Routing is covered by a full sweep of every node position in a 3x3 mesh against every encodable target, host rows included, sent once from each source.

// File: rtl/mesh_egress_pkg.sv
package mesh_egress_pkg;
  localparam int NUM_DIRS = 4;

  // Link indices; the output vectors are ordered by these values.
  typedef enum logic [1:0] {
    DIR_N = 2'd0,
    DIR_E = 2'd1,
    DIR_S = 2'd2,
    DIR_W = 2'd3
  } dir_e;
endpackage

// File: rtl/egress_merge.sv
module egress_merge #(
  parameter int MSG_W = 8
) (
  input  logic             byp_valid,
  input  logic [MSG_W-1:0] byp_data,
  output logic             byp_ready,
  input  logic             loc_valid,
  input  logic [MSG_W-1:0] loc_data,
  output logic             loc_ready,
  output logic             sel_valid,
  output logic [MSG_W-1:0] sel_data,
  input  logic             sel_ready
);
  // Strict priority: pass-through traffic shields the fabric from injection.
  always_comb begin
    sel_valid = byp_valid | loc_valid;
    sel_data  = byp_valid ? byp_data : loc_data;
    byp_ready = sel_ready;
    loc_ready = sel_ready & ~byp_valid;
  end
endmodule

// File: rtl/route_decide.sv
module route_decide
  import mesh_egress_pkg::*;
#(
  parameter int COL_W    = 2,
  parameter int ROW_W    = 2,
  parameter int NUM_ROWS = 3
) (
  input  logic [COL_W-1:0] my_col,
  input  logic [ROW_W-1:0] my_row,
  input  logic [COL_W-1:0] tgt_col,
  input  logic [ROW_W-1:0] tgt_row,
  output dir_e             dir
);
  localparam logic [ROW_W:0] HOST_ROW = (ROW_W+1)'(NUM_ROWS);

  logic to_host;
  assign to_host = {1'b0, tgt_row} >= HOST_ROW;

  always_comb begin
    if (to_host)                dir = DIR_S;
    else if (tgt_col > my_col)  dir = DIR_E;
    else if (tgt_col < my_col)  dir = DIR_W;
    else if (tgt_row < my_row)  dir = DIR_N;
    else                        dir = DIR_S; // further south, or self
  end
endmodule

// File: rtl/egress_slot.sv
module egress_slot #(
  parameter int MSG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [MSG_W-1:0] load_data,
  output logic             free,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [MSG_W-1:0] out_data
);
  assign free = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) out_data <= load_data;
  end
endmodule

// File: rtl/egress_router.sv
module egress_router
  import mesh_egress_pkg::*;
#(
  parameter int COL_W     = 2,
  parameter int ROW_W     = 2,
  parameter int PAYLOAD_W = 4,
  parameter int NUM_ROWS  = 3,
  localparam int MSG_W    = ROW_W + COL_W + PAYLOAD_W
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [COL_W-1:0]                   my_col,
  input  logic [ROW_W-1:0]                   my_row,
  input  logic                               byp_valid,
  output logic                               byp_ready,
  input  logic [MSG_W-1:0]                   byp_data,
  input  logic                               loc_valid,
  output logic                               loc_ready,
  input  logic [MSG_W-1:0]                   loc_data,
  output logic [NUM_DIRS-1:0]                out_valid,
  input  logic [NUM_DIRS-1:0]                out_ready,
  output logic [NUM_DIRS-1:0][MSG_W-1:0]     out_data
);
  localparam int COL_LSB = PAYLOAD_W;
  localparam int ROW_LSB = PAYLOAD_W + COL_W;

  logic             sel_valid;
  logic [MSG_W-1:0] sel_data;
  logic             sel_ready;
  dir_e             sel_dir;
  logic [NUM_DIRS-1:0] slot_free;
  logic [NUM_DIRS-1:0] slot_load;

  egress_merge #(.MSG_W(MSG_W)) u_merge (
    .byp_valid (byp_valid),
    .byp_data  (byp_data),
    .byp_ready (byp_ready),
    .loc_valid (loc_valid),
    .loc_data  (loc_data),
    .loc_ready (loc_ready),
    .sel_valid (sel_valid),
    .sel_data  (sel_data),
    .sel_ready (sel_ready)
  );

  route_decide #(
    .COL_W    (COL_W),
    .ROW_W    (ROW_W),
    .NUM_ROWS (NUM_ROWS)
  ) u_route (
    .my_col  (my_col),
    .my_row  (my_row),
    .tgt_col (sel_data[COL_LSB +: COL_W]),
    .tgt_row (sel_data[ROW_LSB +: ROW_W]),
    .dir     (sel_dir)
  );

  assign sel_ready = slot_free[sel_dir];

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_slot
    assign slot_load[d] = sel_valid & sel_ready & (sel_dir == dir_e'(d));

    egress_slot #(.MSG_W(MSG_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .load      (slot_load[d]),
      .load_data (sel_data),
      .free      (slot_free[d]),
      .out_valid (out_valid[d]),
      .out_ready (out_ready[d]),
      .out_data  (out_data[d])
    );
  end
endmodule

// File: rtl/egress_router_chk.sv
module egress_router_chk #(
  parameter int COL_W     = 2,
  parameter int ROW_W     = 2,
  parameter int PAYLOAD_W = 4,
  parameter int NUM_ROWS  = 3,
  localparam int MSG_W    = ROW_W + COL_W + PAYLOAD_W
) (
  input logic                        clk,
  input logic                        rst,
  input logic [COL_W-1:0]            my_col,
  input logic                        byp_valid,
  input logic                        byp_ready,
  input logic [MSG_W-1:0]            byp_data,
  input logic                        loc_valid,
  input logic                        loc_ready,
  input logic [3:0]                  out_valid,
  input logic [3:0]                  out_ready,
  input logic [3:0][MSG_W-1:0]       out_data
);
  logic [COL_W-1:0] b_col;
  logic [ROW_W:0]   b_row;
  logic             b_take;
  logic             b_host;

  assign b_col  = byp_data[PAYLOAD_W +: COL_W];
  assign b_row  = {1'b0, byp_data[PAYLOAD_W+COL_W +: ROW_W]};
  assign b_take = byp_valid & byp_ready;
  assign b_host = b_row >= (ROW_W+1)'(NUM_ROWS);

  p_byp_wins_r1: assert property (@(posedge clk) disable iff (rst)
    byp_valid && loc_valid |-> !loc_ready);

  p_single_take_r3: assert property (@(posedge clk) disable iff (rst)
    !(b_take && loc_valid && loc_ready));

  p_col_east_r4: assert property (@(posedge clk) disable iff (rst)
    b_take && !b_host && (b_col > my_col)
      |=> out_valid[1] && (out_data[1] == $past(byp_data)));

  p_col_west_r4: assert property (@(posedge clk) disable iff (rst)
    b_take && !b_host && (b_col < my_col)
      |=> out_valid[3] && (out_data[3] == $past(byp_data)));

  p_host_south_r6: assert property (@(posedge clk) disable iff (rst)
    b_take && b_host |=> out_valid[2] && (out_data[2] == $past(byp_data)));

  for (genvar d = 0; d < 4; d++) begin : g_hold
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      out_valid[d] && !out_ready[d] |=> out_valid[d] && $stable(out_data[d]));
  end

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> out_valid == 4'b0000);
endmodule

bind egress_router egress_router_chk #(
  .COL_W     (COL_W),
  .ROW_W     (ROW_W),
  .PAYLOAD_W (PAYLOAD_W),
  .NUM_ROWS  (NUM_ROWS)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .my_col    (my_col),
  .byp_valid (byp_valid),
  .byp_ready (byp_ready),
  .byp_data  (byp_data),
  .loc_valid (loc_valid),
  .loc_ready (loc_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/test_egress_router.sv
module test_egress_router;
  localparam int COL_W = 2, ROW_W = 2, PAYLOAD_W = 4, NUM_ROWS = 3, NUM_COLS = 3;
  localparam int MSG_W = ROW_W + COL_W + PAYLOAD_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [COL_W-1:0] my_col = '0;
  logic [ROW_W-1:0] my_row = '0;
  logic byp_valid = 1'b0, loc_valid = 1'b0;
  logic byp_ready, loc_ready;
  logic [MSG_W-1:0] byp_data = '0, loc_data = '0;
  logic [3:0] out_valid;
  logic [3:0] out_ready = 4'hF;
  logic [3:0][MSG_W-1:0] out_data;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  egress_router #(
    .COL_W(COL_W), .ROW_W(ROW_W), .PAYLOAD_W(PAYLOAD_W), .NUM_ROWS(NUM_ROWS)
  ) i_egress_router (
    .clk(clk), .rst(rst), .my_col(my_col), .my_row(my_row),
    .byp_valid(byp_valid), .byp_ready(byp_ready), .byp_data(byp_data),
    .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_data(loc_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [MSG_W-1:0] mk(int tr, int tc, int pl);
    return {ROW_W'(tr), COL_W'(tc), PAYLOAD_W'(pl)};
  endfunction

  // Expected link from the routing requirements.
  function automatic int exp_dir(int mc, int mr, int tc, int tr);
    if (tr >= NUM_ROWS) return 2;   // R6 host
    if (tc > mc) return 1;          // R4
    if (tc < mc) return 3;          // R4
    if (tr > mr) return 2;          // R5
    if (tr < mr) return 0;          // R5
    return 2;                       // R7 self
  endfunction

  // Sends one message from one source; caller is just after a negedge.
  task automatic send_one(input bit from_loc, input int tc, input int tr, input int pl);
    logic [MSG_W-1:0] m;
    int d;
    m = mk(tr, tc, pl);
    d = exp_dir(int'(my_col), int'(my_row), tc, tr);
    if (from_loc) begin loc_valid = 1'b1; loc_data = m; end
    else          begin byp_valid = 1'b1; byp_data = m; end
    #1;
    if (from_loc) check(loc_ready === 1'b1, "R2 local ready", int'(loc_ready), 1);
    else          check(byp_ready === 1'b1, "R3 bypass ready", int'(byp_ready), 1);
    @(negedge clk);
    byp_valid = 1'b0;
    loc_valid = 1'b0;
    #1;
    check(out_valid === 4'(1 << d), (d == 1 || d == 3) ? "R4 route" :
          (tr >= NUM_ROWS) ? "R6 route" : (d == 2 && tr == int'(my_row) &&
          tc == int'(my_col)) ? "R7 route" : "R5 route", int'(out_valid), 1 << d);
    check(out_data[d] === m, "R9 data", int'(out_data[d]), int'(m));
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(out_valid === 4'b0000, "R10 reset state", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;

    // Full routing sweep, both sources.
    for (int src = 0; src < 2; src++)
      for (int mc = 0; mc < NUM_COLS; mc++)
        for (int mr = 0; mr < NUM_ROWS; mr++) begin
          my_col = COL_W'(mc);
          my_row = ROW_W'(mr);
          for (int tr = 0; tr < (1 << ROW_W); tr++)
            for (int tc = 0; tc < (1 << COL_W); tc++)
              send_one(src[0], tc, tr, (tr * 4 + tc + src) & 15);
        end

    // R1: both valid, bypass wins, local follows.
    @(negedge clk);
    my_col = 2'd1; my_row = 2'd1;
    byp_valid = 1'b1; byp_data = mk(1, 2, 5);
    loc_valid = 1'b1; loc_data = mk(1, 0, 9);
    #1;
    check(byp_ready === 1'b1, "R1 bypass ready", int'(byp_ready), 1);
    check(loc_ready === 1'b0, "R1 local held", int'(loc_ready), 0);
    @(negedge clk);
    byp_valid = 1'b0;
    #1;
    check(out_valid === 4'b0010, "R1 bypass east", int'(out_valid), 2);
    check(out_data[1] === mk(1, 2, 5), "R1 bypass data", int'(out_data[1]), int'(mk(1, 2, 5)));
    check(loc_ready === 1'b1, "R2 local ready", int'(loc_ready), 1);
    @(negedge clk);
    loc_valid = 1'b0;
    #1;
    check(out_valid === 4'b1000, "R2 local west", int'(out_valid), 8);
    check(out_data[3] === mk(1, 0, 9), "R2 local data", int'(out_data[3]), int'(mk(1, 0, 9)));

    // R8 + R1: south stalled, local bound east must still wait.
    @(negedge clk);
    out_ready = 4'b1011;
    byp_valid = 1'b1; byp_data = mk(2, 1, 3);
    @(negedge clk);
    byp_data = mk(3, 0, 4);
    loc_valid = 1'b1; loc_data = mk(0, 2, 6);
    for (int k = 0; k < 4; k++) begin
      #1;
      check(out_valid === 4'b0100, "R8 held valid", int'(out_valid), 4);
      check(out_data[2] === mk(2, 1, 3), "R8 held data", int'(out_data[2]), int'(mk(2, 1, 3)));
      check(byp_ready === 1'b0, "R8 bypass stalled", int'(byp_ready), 0);
      check(loc_ready === 1'b0, "R1 local blocked", int'(loc_ready), 0);
      @(negedge clk);
    end
    out_ready = 4'hF;
    #1;
    check(byp_ready === 1'b1, "R8 drain ready", int'(byp_ready), 1);
    check(loc_ready === 1'b0, "R1 local still held", int'(loc_ready), 0);
    @(negedge clk);
    byp_valid = 1'b0;
    #1;
    check(out_valid === 4'b0100, "R8 second message", int'(out_valid), 4);
    check(out_data[2] === mk(3, 0, 4), "R8 no loss", int'(out_data[2]), int'(mk(3, 0, 4)));
    @(negedge clk);
    loc_valid = 1'b0;
    #1;
    check(out_valid === 4'b0010, "R9 south drained, local east", int'(out_valid), 2);
    check(out_data[1] === mk(0, 2, 6), "R2 local data", int'(out_data[1]), int'(mk(0, 2, 6)));
    @(negedge clk);
    #1;
    check(out_valid === 4'b0000, "R9 valid falls", int'(out_valid), 0);

    // R10: reset clears a stalled output.
    @(negedge clk);
    out_ready = 4'b0000;
    byp_valid = 1'b1; byp_data = mk(0, 1, 7);
    @(negedge clk);
    byp_valid = 1'b0;
    #1;
    check(out_valid === 4'b0001, "R5 north loaded", int'(out_valid), 1);
    rst = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid === 4'b0000, "R10 reset clears", int'(out_valid), 0);
    rst = 1'b0;
    out_ready = 4'hF;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule